// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a countdown watchdog that gives software two chances before forcing a reset. A counter runs down from a programmed reload value. When it expires while the interrupt line is low, it raises the interrupt and starts a new period. The interrupt is a warning. If software has not cleared it by the time the next period expires, the block raises a sticky reset request.

Software uses a small register port to keep the block alive. It writes a reload value, turns counting on or off, and services the block by writing to the clear location. That write lowers the interrupt, restarts the period and cancels the pending escalation.

A debug-halt input freezes the count while a processor is stopped under a debugger. The register port is a plain write strobe with a combinational read. No stream interface is involved, so there is no back-pressure.

Top module: `wdog_twostage`

## Requirements
- R1: While enabled, not halted and not written, `count` drops by exactly one on each rising clock edge while it is nonzero.
- R2: On an enabled, unhalted edge where `count` is 0, `irq` goes high and `count` takes the reload value. The period is therefore reload value + 1 cycles.
- R3: A timeout that occurs while `irq` is already high sets `rst_req`. `rst_req` never rises unless `irq` was high in the previous cycle.
- R4: Once set, `rst_req` stays high until `rst_n` is asserted, even if `irq` is cleared.
- R5: A write to address 2 (clear) lowers `irq` on that edge and reloads `count` from the stored reload value. A further timeout then raises only `irq`, not `rst_req`.
- R6: A write to address 0 stores the reload value and loads `count` with it on the same edge.
- R7: Bit 0 of address 1 is the enable. While it is 0, `count` holds its value and neither `irq` nor `rst_req` rises.
- R8: While `dbg_halt` is high, `count` holds. Counting resumes from the held value once `dbg_halt` falls.
- R9: A reload value of 0 makes a timeout occur on the first enabled, unhalted edge after the load.
- R10: After reset, the outputs and registers are as follows:
  - `count` and the stored reload value equal `LOAD_RST`.
  - Enable is 0.
  - `irq` and `rst_req` are 0.
  - Reads return the reload value at address 0 and the enable at address 1.
  - Reads at address 3 return {`rst_req`, `irq`} in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 reload, 1 control, 2 clear |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| dbg_halt | input | 1 | Freezes counting while high |
| irq | output | 1 | Level interrupt, first stage |
| rst_req | output | 1 | Sticky reset request, second stage |
| count | output | CNT_W | Current counter value |

## Verification
Every result is registered and appears on the clock edge that follows the cause:
- A reload or clear write is visible right after its own edge.
- With reload value N, the first interrupt is due N+1 edges after the enabling edge.
- The reset request is due a further N+1 edges after that.

The bench drives and samples on falling edges and counts edges explicitly. It checks each output one edge before it is due (still low) and again on the edge where it is due (now high). That pins the exact cycle rather than a window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_LOAD   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_STATUS = 2'd3
  } wd_reg_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              irq,
  input  logic              rst_req,
  output logic [CNT_W-1:0]  rd_data,
  output logic              en,
  output logic              reload,
  output logic [CNT_W-1:0]  reload_val,
  output logic              clr
);
  logic [CNT_W-1:0] load_q;
  logic             wr_load, wr_ctrl;

  assign wr_load = wr_en && (wd_reg_e'(wr_addr) == REG_LOAD);
  assign wr_ctrl = wr_en && (wd_reg_e'(wr_addr) == REG_CTRL);
  assign clr     = wr_en && (wd_reg_e'(wr_addr) == REG_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= LOAD_RST;
      en     <= 1'b0;
    end else begin
      if (wr_load) load_q <= wr_data;
      if (wr_ctrl) en     <= wr_data[0];
    end
  end

  assign reload     = wr_load || clr;
  assign reload_val = wr_load ? wr_data : load_q;

  always_comb begin
    rd_data = '0;
    unique case (wd_reg_e'(rd_addr))
      REG_LOAD:   rd_data = load_q;
      REG_CTRL:   rd_data[0] = en;
      REG_CLEAR:  rd_data = '0;
      REG_STATUS: rd_data[1:0] = {rst_req, irq};
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             halt,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  logic active;

  assign active  = en && !halt && !reload;
  assign timeout = active && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= LOAD_RST;
    else if (reload)  count <= reload_val;
    else if (timeout) count <= reload_val;
    else if (active)  count <= count - 1'b1;
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout,
  input  logic clr,
  output logic irq,
  output logic rst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (clr)                 irq <= 1'b0;
      else if (timeout)        irq <= 1'b1;
      if (timeout && irq)      rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              dbg_halt,
  output logic              irq,
  output logic              rst_req,
  output logic [CNT_W-1:0]  count
);
  logic             en_q, reload, clr, timeout;
  logic [CNT_W-1:0] reload_val;

  wdog_regs #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .irq(irq), .rst_req(rst_req),
    .rd_data(rd_data), .en(en_q), .reload(reload),
    .reload_val(reload_val), .clr(clr)
  );

  wdog_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .halt(dbg_halt),
    .reload(reload), .reload_val(reload_val), .count(count),
    .timeout(timeout)
  );

  wdog_escalate u_esc (
    .clk(clk), .rst_n(rst_n), .timeout(timeout), .clr(clr),
    .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             dbg_halt,
  input logic             en,
  input logic             irq,
  input logic             rst_req,
  input logic [CNT_W-1:0] count
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !dbg_halt && !wr_en && count != '0) |=> (count == $past(count) - 1'b1)); // R1
  AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(irq)); // R3
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req); // R4
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> !irq); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en) |=> ($stable(count) && !$rose(irq) && !$rose(rst_req))); // R7
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !wr_en) |=> $stable(count)); // R8
endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .dbg_halt(dbg_halt), .en(en_q), .irq(irq), .rst_req(rst_req),
  .count(count)
);

// File: tb/wdog_twostage_tb.sv
module wdog_twostage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam logic [W-1:0] RST_LOAD = 32'd100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         dbg_halt = 1'b0;
  logic         irq, rst_req;
  logic [W-1:0] count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_twostage #(.CNT_W(W), .LOAD_RST(RST_LOAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_halt(dbg_halt), .irq(irq), .rst_req(rst_req), .count(count)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dbg_halt = 1'b0; wr_en = 1'b0;
    wait_neg(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R10 count", count, RST_LOAD);
    check("R10 irq", irq, 0);
    check("R10 rst_req", rst_req, 0);
    rd_addr = 2'd0; #1; check("R10 read load", rd_data, RST_LOAD);
    rd_addr = 2'd1; #1; check("R10 read enable", rd_data, 0);
    wait_neg(5);
    check("R10 idle count holds", count, RST_LOAD);
  endtask

  task automatic t_escalate();
    do_reset();
    wr(2'd0, 5);
    wr(2'd1, 1);
    wait_neg(3); check("R1 count steps", count, 2);
    wait_neg(2); check("R2 irq not yet", irq, 0);
    wait_neg(1); check("R2 irq on timeout", irq, 1);
    check("R2 count reloads", count, 5);
    wait_neg(5); check("R3 rst_req not yet", rst_req, 0);
    wait_neg(1); check("R3 rst_req on second timeout", rst_req, 1);
    rd_addr = 2'd3; #1; check("R10 status read", rd_data, 3);
    wr(2'd2, 0);
    check("R5 clear drops irq", irq, 0);
    check("R4 rst_req sticky after clear", rst_req, 1);
    wait_neg(20); check("R4 rst_req still high", rst_req, 1);
    do_reset();
    check("R4 rst_req cleared by reset", rst_req, 0);
  endtask

  task automatic t_service();
    do_reset();
    wr(2'd0, 5);
    wr(2'd1, 1);
    wait_neg(6); check("R2 irq raised", irq, 1);
    wait_neg(3);
    wr(2'd2, 0);
    check("R5 irq cleared", irq, 0);
    check("R5 count reloaded", count, 5);
    wait_neg(6);
    check("R5 irq again after full period", irq, 1);
    check("R5 no escalation after service", rst_req, 0);
    for (int k = 0; k < 4; k++) begin
      wr(2'd2, 0);
      wait_neg(4);
    end
    check("R5 regular service keeps irq low", irq, 0);
    check("R5 regular service keeps rst_req low", rst_req, 0);
  endtask

  task automatic t_disable();
    do_reset();
    wr(2'd0, 10);
    wr(2'd1, 1);
    wait_neg(3); check("R1 count after 3", count, 7);
    wr(2'd1, 0);
    check("R7 last step on disabling edge", count, 6);
    wait_neg(20);
    check("R7 count holds while disabled", count, 6);
    check("R7 no irq while disabled", irq, 0);
    check("R7 no rst_req while disabled", rst_req, 0);
  endtask

  task automatic t_halt();
    do_reset();
    wr(2'd0, 10);
    wr(2'd1, 1);
    wait_neg(2);
    dbg_halt = 1'b1;
    wait_neg(10);
    check("R8 count frozen in halt", count, 8);
    check("R8 no irq in halt", irq, 0);
    dbg_halt = 1'b0;
    wait_neg(1);
    check("R8 resumes from held value", count, 7);
  endtask

  task automatic t_load_zero();
    do_reset();
    wr(2'd1, 1);
    wr(2'd0, 0);
    check("R9 count zero after load", count, 0);
    check("R9 irq not yet", irq, 0);
    wait_neg(1);
    check("R9 timeout next cycle", irq, 1);
  endtask

  task automatic t_load_immediate();
    do_reset();
    wr(2'd1, 1);
    wr(2'd0, 20);
    wait_neg(3); check("R1 count from 20", count, 17);
    wr(2'd0, 7);
    check("R6 load takes effect at once", count, 7);
    rd_addr = 2'd0; #1; check("R6 load readback", rd_data, 7);
    rd_addr = 2'd1; #1; check("R7 enable readback", rd_data, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_escalate();
        t_service();
        t_disable();
        t_halt();
        t_load_zero();
        t_load_immediate();
      end
      begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule